// File: doc/BRIEF.md
# Fuse Sense-Latch Read Sequencer

This block generates the four digital controls that a bank of fuse sense latches needs in order to capture the state of their fuses: an active-low precharge, a latch-feedback enable and two sense-path enables. At rest it holds the latches in their storing condition. A start request launches a fixed walk through four timed steps. First the feedback loop is opened with the precharge active. Next the sense path through the fuse is enabled. Then the precharge is released while sensing continues. Finally the loop is closed again and the block returns to rest.

Each step lasts a programmable number of clock cycles so that slow analog nodes can settle. The dwell value is captured when the sequence starts. A test-select input routes four external test-control pins straight to the outputs in place of the sequencer. While that input is high, no sequence may be launched, so the test controls and the sequencer are both settled before a read begins. The block reports busy during the walk and a one-cycle done pulse when it ends.

Top module: `efs_sense_seq`

## Requirements
- R1: After reset the outputs are the rest encoding (precharge_n=1, feedback=1, sense_a=0, sense_b=0), with busy=0 and done=0.
- R2: In the first step after a start is accepted, all four controls are 0 (precharge_n=0, feedback=0, sense_a=0, sense_b=0).
- R3: In the second step the controls are precharge_n=0, feedback=0, sense_a=1, sense_b=1.
- R4: In the third step the controls are precharge_n=1, feedback=0, sense_a=1, sense_b=1. A latch driven by these controls takes its fuse value only on the change from this step to the fourth, and holds its value in every other step.
- R5: In the fourth step the controls are precharge_n=1, feedback=1, sense_a=0, sense_b=0, and afterwards the block is back at rest with the same encoding.
- R6: Each of the four steps lasts D cycles, where D is the dwell input sampled in the cycle the start is accepted, and a dwell of 0 is treated as 1.
- R7: A change of the dwell input during a running sequence has no effect on its step lengths.
- R8: A start request made while a sequence runs is ignored, so the step order and the step lengths are unchanged.
- R9: busy is 1 exactly during the four steps. done is 1 for one cycle, the first cycle back at rest, and is never 1 together with busy.
- R10: With test-select at 1, the four outputs equal the four test-control pins in the same cycle.
- R11: A start request made while test-select is 1 is ignored: busy stays 0 and the controls keep following the test pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one read sequence |
| test_sel_i | input | 1 | 1 selects the external test controls for the outputs |
| tst_pre_n_i | input | 1 | External precharge control (active low) |
| tst_fb_i | input | 1 | External latch-feedback control |
| tst_sen_a_i | input | 1 | External sense enable A |
| tst_sen_b_i | input | 1 | External sense enable B |
| dwell_i | input | CNT_W | Cycles per step, 0 treated as 1 |
| pre_n_o | output | 1 | Precharge control to the latches (active low) |
| fb_o | output | 1 | Latch-feedback control |
| sen_a_o | output | 1 | Sense enable A |
| sen_b_o | output | 1 | Sense enable B |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A start sampled at a clock edge puts the first step's encoding on the outputs right after that edge. Each later step appears D edges after the one before it, and done follows 4·D edges after the start. The test-pin path is combinational and has no delay. The bench drives inputs on the falling edge and keeps its own cycle count for each step. It compares the whole control word, busy and done against the expected value at every falling edge of the sequence, so a step that is one cycle early or late is seen at once. A behavioural latch model advanced at the same points confirms the capture instant.

// File: rtl/efs_pkg.sv
package efs_pkg;

   typedef enum logic [2:0] {
      ST_REST    = 3'd0,
      ST_OPEN    = 3'd1,
      ST_SENSE   = 3'd2,
      ST_RELEASE = 3'd3,
      ST_CLOSE   = 3'd4
   } step_e;

   typedef struct packed {
      logic pre_n;
      logic fb;
      logic sen_a;
      logic sen_b;
   } ctrl_t;

   localparam ctrl_t CTRL_REST = '{pre_n: 1'b1, fb: 1'b1, sen_a: 1'b0, sen_b: 1'b0};

endpackage

// File: rtl/efs_step_timer.sv
module efs_step_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic             reload_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] dwell_i,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] dwell_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff_dwell;

   assign eff_dwell = (dwell_i == '0) ? ONE : dwell_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dwell_q <= ONE;
         cnt_q   <= '0;
      end else if (capture_i) begin
         dwell_q <= eff_dwell;
         cnt_q   <= eff_dwell - ONE;
      end else if (reload_i) begin
         cnt_q   <= dwell_q - ONE;
      end else if (run_i && cnt_q != '0) begin
         cnt_q   <= cnt_q - ONE;
      end
   end

   assign last_o = (cnt_q == '0);

   // R6: the stored dwell is never zero and the count stays below it
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dwell_q != '0) && (cnt_q < dwell_q));

   // R7: the dwell in use only changes when a new sequence is captured
   p_dwell_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(dwell_q));
endmodule

// File: rtl/efs_seq_fsm.sv
module efs_seq_fsm
   import efs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  test_sel_i,
   input  logic  last_i,
   output logic  capture_o,
   output logic  reload_o,
   output logic  run_o,
   output step_e step_o,
   output logic  busy_o,
   output logic  done_o
);
   step_e step_q;
   step_e step_nx;
   logic  done_q;
   logic  accept;
   logic  advance;

   assign accept  = (step_q == ST_REST) && start_i && !test_sel_i;
   assign advance = (step_q != ST_REST) && last_i;

   always_comb begin
      step_nx = step_q;
      if (accept) begin
         step_nx = ST_OPEN;
      end else if (advance) begin
         unique case (step_q)
            ST_OPEN:    step_nx = ST_SENSE;
            ST_SENSE:   step_nx = ST_RELEASE;
            ST_RELEASE: step_nx = ST_CLOSE;
            default:    step_nx = ST_REST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_REST;
         done_q <= 1'b0;
      end else begin
         step_q <= step_nx;
         done_q <= advance && (step_q == ST_CLOSE);
      end
   end

   assign capture_o = accept;
   assign reload_o  = advance && (step_q != ST_CLOSE);
   assign run_o     = (step_q != ST_REST);
   assign step_o    = step_q;
   assign busy_o    = (step_q != ST_REST);
   assign done_o    = done_q;

   // R6: no step is left before its timer expires
   p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_REST) && !last_i |=> step_q == $past(step_q));

   // R8: a start during a running step leaves that step in place
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (step_q != ST_REST) && !last_i |=> $stable(step_q));

   // R9: done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/efs_ctrl_encode.sv
module efs_ctrl_encode
   import efs_pkg::*;
(
   input  step_e step_i,
   output ctrl_t ctrl_o
);
   always_comb begin
      unique case (step_i)
         ST_OPEN:    ctrl_o = '{pre_n: 1'b0, fb: 1'b0, sen_a: 1'b0, sen_b: 1'b0};
         ST_SENSE:   ctrl_o = '{pre_n: 1'b0, fb: 1'b0, sen_a: 1'b1, sen_b: 1'b1};
         ST_RELEASE: ctrl_o = '{pre_n: 1'b1, fb: 1'b0, sen_a: 1'b1, sen_b: 1'b1};
         default:    ctrl_o = CTRL_REST;
      endcase
   end

   // R4: the sense path is never enabled while the latch loop is closed
   always_comb begin
      a_no_fight_r4: assert ((ctrl_o.sen_a | ctrl_o.sen_b) -> !ctrl_o.fb);
   end
endmodule

// File: rtl/efs_out_mux.sv
module efs_out_mux
   import efs_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  test_sel_i,
   input  ctrl_t seq_i,
   input  ctrl_t tst_i,
   output ctrl_t ctrl_o
);
   ctrl_t pick;

   assign pick = test_sel_i ? tst_i : seq_i;

   generate
      if (OUT_REG) begin : g_reg
         ctrl_t ctrl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctrl_q <= CTRL_REST;
            else        ctrl_q <= pick;
         end
         assign ctrl_o = ctrl_q;
      end else begin : g_comb
         assign ctrl_o = pick;
      end
   endgenerate
endmodule

// File: rtl/efs_sense_seq.sv
module efs_sense_seq
   import efs_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             test_sel_i,
   input  logic             tst_pre_n_i,
   input  logic             tst_fb_i,
   input  logic             tst_sen_a_i,
   input  logic             tst_sen_b_i,
   input  logic [CNT_W-1:0] dwell_i,
   output logic             pre_n_o,
   output logic             fb_o,
   output logic             sen_a_o,
   output logic             sen_b_o,
   output logic             busy_o,
   output logic             done_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("efs_sense_seq: CNT_W must lie in 1..32");
      end
   endgenerate

   logic  capture;
   logic  reload;
   logic  run;
   logic  last;
   step_e step;
   ctrl_t seq_ctrl;
   ctrl_t tst_ctrl;
   ctrl_t out_ctrl;

   efs_step_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .reload_i  (reload),
      .run_i     (run),
      .dwell_i   (dwell_i),
      .last_o    (last)
   );

   efs_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .test_sel_i (test_sel_i),
      .last_i     (last),
      .capture_o  (capture),
      .reload_o   (reload),
      .run_o      (run),
      .step_o     (step),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   efs_ctrl_encode u_enc (
      .step_i (step),
      .ctrl_o (seq_ctrl)
   );

   assign tst_ctrl = '{pre_n: tst_pre_n_i, fb: tst_fb_i, sen_a: tst_sen_a_i, sen_b: tst_sen_b_i};

   efs_out_mux #(.OUT_REG(OUT_REG)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_sel_i (test_sel_i),
      .seq_i      (seq_ctrl),
      .tst_i      (tst_ctrl),
      .ctrl_o     (out_ctrl)
   );

   assign pre_n_o = out_ctrl.pre_n;
   assign fb_o    = out_ctrl.fb;
   assign sen_a_o = out_ctrl.sen_a;
   assign sen_b_o = out_ctrl.sen_b;

   // R11: a sequence only begins from an accepted start outside test mode
   p_start_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i) && !$past(test_sel_i));

   // R9: done and busy are never high together
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R5: when a sequence ends, the sequencer word is back at rest
   p_end_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> seq_ctrl == CTRL_REST);
endmodule

// File: tb/efs_sense_seq_tb.sv
module efs_sense_seq_tb;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic             test_sel_i = 1'b0;
   logic             tst_pre_n_i = 1'b1;
   logic             tst_fb_i = 1'b1;
   logic             tst_sen_a_i = 1'b0;
   logic             tst_sen_b_i = 1'b0;
   logic [CNT_W-1:0] dwell_i = '0;
   logic             pre_n_o, fb_o, sen_a_o, sen_b_o, busy_o, done_o;

   int errors = 0;
   int checks = 0;

   // behavioural sense-latch model
   logic [3:0] prev_word = 4'b1100;
   logic       fuse_val = 1'b0;
   logic       latch_val = 1'b0;

   always #5 clk = ~clk;

   efs_sense_seq #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_sel_i(test_sel_i),
      .tst_pre_n_i(tst_pre_n_i), .tst_fb_i(tst_fb_i),
      .tst_sen_a_i(tst_sen_a_i), .tst_sen_b_i(tst_sen_b_i),
      .dwell_i(dwell_i), .pre_n_o(pre_n_o), .fb_o(fb_o),
      .sen_a_o(sen_a_o), .sen_b_o(sen_b_o), .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [3:0] exp_word(input int s);
      case (s)
         1: return 4'b0000;
         2: return 4'b0011;
         3: return 4'b1011;
         default: return 4'b1100;
      endcase
   endfunction

   function automatic logic [3:0] word();
      return {pre_n_o, fb_o, sen_a_o, sen_b_o};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // advance the latch model using the word seen this cycle
   task automatic latch_step();
      if (prev_word == 4'b1011 && word() == 4'b1100) latch_val = fuse_val;
      prev_word = word();
   endtask

   task automatic run_seq(input int dw, input bit poke, input bit chg_dw);
      int  d;
      logic old_latch;
      d = (dw == 0) ? 1 : dw;
      @(negedge clk);
      dwell_i  = dw[CNT_W-1:0];
      start_i  = 1'b1;
      fuse_val = 1'($urandom);
      @(negedge clk);
      start_i   = 1'b0;
      old_latch = latch_val;
      for (int s = 1; s <= 4; s++) begin
         for (int c = 0; c < d; c++) begin
            latch_step();
            case (s)
               1: chk(word() == exp_word(1), "R2 step1 word", word(), exp_word(1));
               2: chk(word() == exp_word(2), "R3 step2 word", word(), exp_word(2));
               3: chk(word() == exp_word(3), "R4 step3 word", word(), exp_word(3));
               default: chk(word() == exp_word(4), "R5 step4 word", word(), exp_word(4));
            endcase
            chk(busy_o == 1'b1 && done_o == 1'b0, "R9 busy during steps", {busy_o, done_o}, 2'b10);
            if (s < 4)
               chk(latch_val == old_latch, "R4 latch unchanged before capture", latch_val, old_latch);
            else
               chk(latch_val == fuse_val, "R4 latch captured on step3 exit", latch_val, fuse_val);
            if (chg_dw && s == 1 && c == 0) dwell_i = CNT_W'(dw + 3); // R7
            if (poke && s == 2 && c == 0) start_i = 1'b1;             // R8
            @(negedge clk);
            start_i = 1'b0;
         end
      end
      latch_step();
      chk(word() == 4'b1100, "R5 back at rest", word(), 4'hC);
      chk(busy_o == 1'b0 && done_o == 1'b1, "R9 done pulse after step4 (R6 length)", {busy_o, done_o}, 2'b01);
      chk(latch_val == fuse_val, "R4 latch holds at rest", latch_val, fuse_val);
      @(negedge clk);
      latch_step();
      chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done single cycle", {busy_o, done_o}, 2'b00);
   endtask

   task automatic test_mode(input int n);
      test_sel_i = 1'b1;
      for (int i = 0; i < n; i++) begin
         logic [3:0] v;
         v = 4'($urandom);
         {tst_pre_n_i, tst_fb_i, tst_sen_a_i, tst_sen_b_i} = v;
         start_i = (i % 3 == 0);
         #1;
         chk(word() == v, "R10 test pins pass through", word(), v);
         @(negedge clk);
         chk(busy_o == 1'b0, "R11 start ignored in test mode", busy_o, 0);
      end
      start_i = 1'b0;
      {tst_pre_n_i, tst_fb_i, tst_sen_a_i, tst_sen_b_i} = 4'b1100;
   endtask

   initial begin
      void'($urandom(32'h5eed_0bad));
      #3;
      chk(word() == 4'b1100, "R1 reset word", word(), 4'hC);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {busy_o, done_o}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(word() == 4'b1100 && !busy_o, "R1 rest after reset", word(), 4'hC);

      // directed corners
      run_seq(1, 1'b0, 1'b0);
      run_seq(0, 1'b0, 1'b0);   // R6 zero dwell acts as one
      run_seq(4, 1'b1, 1'b0);   // R8 start while busy
      run_seq(3, 1'b0, 1'b1);   // R7 dwell change mid-run
      run_seq(9, 1'b1, 1'b1);

      test_mode(8);
      test_sel_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b0 && word() == 4'b1100, "R11 idle after test mode", word(), 4'hC);

      // random mix
      for (int k = 0; k < 12; k++) begin
         run_seq(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom));
         repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk(busy_o == 1'b0 && word() == 4'b1100, "R5 rest between runs", word(), 4'hC);
         end
      end
      test_mode(4);
      test_sel_i = 1'b0;
      run_seq(2, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule